// File: doc/BRIEF.md
# E1 Signalling Multiframe Timeslot-16 Inserter

This block sits in the transmit path of an E1 framer and rewrites timeslot 16 so that the line carries a 16-frame channel-associated signalling multiframe. It receives the serial stream one bit per clock, together with the frame number, timeslot number and bit number from the framer's shared counters. It returns the stream one clock later with the TS16 bits it owns replaced.

In frame 0 of the multiframe, the block writes three things into TS16:
- the alignment nibble `0000` in bits 1 to 4;
- an optional 3-bit spare value in bits 5, 7 and 8;
- a programmable remote multiframe alarm bit in bit 6.

Two overrides can force every TS16 bit in every frame to zero or to one. Zero wins when both are set.

A single-pulse request inverts exactly one later alignment nibble. This is used to inject an alignment error for test.

Top module: `cas_mf_inserter`

## Requirements
- R1: While `rst_n` is low, `dout` is 1. Out of reset, `dout` in a cycle carries the result for the inputs sampled at the previous rising edge, so the latency is one clock.
- R2: Any bit whose `slot_idx` is not 16 comes out equal to `din`. With no override active, TS16 bits of frames 1 to 15 also come out equal to `din`.
- R3: Multiframe generation is on when `framing_en` and `sig_gen` are both 1. While it is on and no override is active, TS16 bits 1 to 4 of frame 0 come out as 0. Bit n of the slot has `bit_idx` = n-1.
- R4: While generation is on, `spare_dis` is 0 and no override is active, frame-0 TS16 bits 5, 7 and 8 carry `spare_val[2]`, `spare_val[1]` and `spare_val[0]`. While `spare_dis` is 1, those three bits come out equal to `din`.
- R5: While generation is on and no override is active, frame-0 TS16 bit 6 carries `y_alarm`.
- R6: While `framing_en` is 1, `force_one` is 1 and `force_zero` is 0, every TS16 bit of every frame comes out as 1. This overrides R3 to R5.
- R7: While `framing_en` is 1 and `force_zero` is 1, every TS16 bit of every frame comes out as 0, whatever `force_one` is.
- R8: While `framing_en` is 1 and `sig_gen` is 0, frame-0 TS16 comes out equal to `din` unless an override is active.
- R9: A one-cycle `inv_req` pulse is held until the next frame-0 TS16 bit-1 cycle that comes strictly after the pulse while generation is on. That one nibble comes out as `1111`, and the request is then cleared. A request that arrives during or after the bit-1 cycle of a nibble waits for the following multiframe. Several requests before one nibble give a single inversion. A nibble masked by an override still uses up the request.
- R10: While `framing_en` is 0, `dout` equals `din` for every bit, and the overrides have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial data in |
| frame_idx | input | 4 | Frame number within the 16-frame multiframe |
| slot_idx | input | 5 | Timeslot number 0 to 31 |
| bit_idx | input | 3 | Bit number within the slot; 0 is bit 1, sent first |
| framing_en | input | 1 | Framing enabled |
| sig_gen | input | 1 | Signalling multiframe selected |
| spare_dis | input | 1 | 1 leaves bits 5, 7 and 8 untouched |
| spare_val | input | 3 | Values for bits 5, 7 and 8 |
| y_alarm | input | 1 | Multiframe alarm bit for bit 6 |
| force_zero | input | 1 | Force all of TS16 to zero |
| force_one | input | 1 | Force all of TS16 to one |
| inv_req | input | 1 | Pulse requesting one inverted alignment nibble |
| dout | output | 1 | Serial data out |

## Verification
Each setting is run over whole multiframes of random data, and a behavioural model predicts every output bit. The settings are:
- two spare and alarm combinations, which show that each frame-0 field lands in its own bit position;
- generation turned off by `sig_gen`, which separates multiframe insertion from plain pass-through;
- all-ones, then both overrides together, which expose both the override priority and the override's reach into frames 1 to 15;
- framing disabled with an override set, which shows the override being ignored.

Inversion requests are placed in three positions:
- in the middle of a nibble;
- on the nibble's first bit;
- in a multiframe masked by an override.

These placements show whether the inversion is deferred, applied once and then consumed.

// File: rtl/cas_mf_inserter.sv
module cas_mf_inserter #(
  parameter int SIG_SLOT = 16,
  parameter int NIB_BITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [3:0] frame_idx,
  input  logic [4:0] slot_idx,
  input  logic [2:0] bit_idx,
  input  logic       framing_en,
  input  logic       sig_gen,
  input  logic       spare_dis,
  input  logic [2:0] spare_val,
  input  logic       y_alarm,
  input  logic       force_zero,
  input  logic       force_one,
  input  logic       inv_req,
  output logic       dout
);
  localparam logic [4:0] SLOT_ID  = SIG_SLOT[4:0];
  localparam logic [2:0] NIB_LAST = 3'(NIB_BITS - 1);

  logic in_sig, mf_on, at_mf0, nib_start, inv_pending, inv_active, inv_now, nxt;

  assign in_sig    = slot_idx == SLOT_ID;
  assign mf_on     = framing_en && sig_gen;
  assign at_mf0    = mf_on && in_sig && frame_idx == 4'd0;
  assign nib_start = at_mf0 && bit_idx == 3'd0;
  assign inv_now   = (bit_idx == 3'd0) ? inv_pending : inv_active;

  always_comb begin
    nxt = din;
    if (framing_en && in_sig) begin
      if (force_zero)     nxt = 1'b0;
      else if (force_one) nxt = 1'b1;
      else if (at_mf0) begin
        case (bit_idx)
          3'd4:    nxt = spare_dis ? din : spare_val[2];
          3'd5:    nxt = y_alarm;
          3'd6:    nxt = spare_dis ? din : spare_val[1];
          3'd7:    nxt = spare_dis ? din : spare_val[0];
          default: nxt = inv_now;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout        <= 1'b1;
      inv_pending <= 1'b0;
      inv_active  <= 1'b0;
    end else begin
      dout <= nxt;
      if (nib_start) begin
        inv_active  <= inv_pending;
        inv_pending <= inv_req;
      end else begin
        inv_pending <= inv_pending | inv_req;
        if (at_mf0 && bit_idx == NIB_LAST) inv_active <= 1'b0;
      end
    end
  end

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != SLOT_ID) |=> dout == $past(din));
  assert_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (framing_en && in_sig && force_one && !force_zero) |=> dout);
  assert_zero_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (framing_en && in_sig && force_zero) |=> !dout);
  assert_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mf0 && bit_idx == 3'd5 && !force_zero && !force_one) |=> dout == $past(y_alarm));
  assert_req_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_start && !inv_req) |=> !inv_pending);
  assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !framing_en |=> dout == $past(din));
endmodule

// File: tb/test_cas_mf_inserter.sv
module test_cas_mf_inserter;
  logic clk = 0;
  logic rst_n = 0;
  logic din = 0;
  logic [3:0] frame_idx = 0;
  logic [4:0] slot_idx = 0;
  logic [2:0] bit_idx = 0;
  logic framing_en = 0, sig_gen = 0, spare_dis = 0, y_alarm = 0;
  logic [2:0] spare_val = 0;
  logic force_zero = 0, force_one = 0, inv_req = 0;
  logic dout;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit have_exp = 0;
  bit exp_bit;
  string exp_tag;
  bit m_pend = 0;
  bit m_nib = 0;

  always #5 clk = ~clk;

  cas_mf_inserter i_cas_mf_inserter (
    .clk(clk), .rst_n(rst_n), .din(din), .frame_idx(frame_idx),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .framing_en(framing_en),
    .sig_gen(sig_gen), .spare_dis(spare_dis), .spare_val(spare_val),
    .y_alarm(y_alarm), .force_zero(force_zero), .force_one(force_one),
    .inv_req(inv_req), .dout(dout)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%0b expected %0b (frame %0d slot %0d bit %0d)",
               tag, act, exp, frame_idx, slot_idx, bit_idx);
    end
  endtask

  task automatic predict();
    bool_dummy();
    exp_bit = din;
    exp_tag = "R2";
    if (!framing_en) begin
      exp_tag = "R10";
    end else if (slot_idx == 16) begin
      if (force_zero) begin
        exp_bit = 0; exp_tag = "R7";
      end else if (force_one) begin
        exp_bit = 1; exp_tag = "R6";
      end else if (!sig_gen) begin
        exp_tag = (frame_idx == 0) ? "R8" : "R2";
      end else if (frame_idx == 0) begin
        if (bit_idx < 4) begin
          exp_bit = (bit_idx == 0) ? m_pend : m_nib;
          exp_tag = "R3/R9";
        end else if (bit_idx == 5) begin
          exp_bit = y_alarm; exp_tag = "R5";
        end else begin
          exp_tag = "R4";
          if (!spare_dis)
            exp_bit = (bit_idx == 4) ? spare_val[2] : (bit_idx == 6) ? spare_val[1] : spare_val[0];
        end
      end
    end
    if (framing_en && sig_gen && slot_idx == 16 && frame_idx == 0 && bit_idx == 0) begin
      m_nib = m_pend;
      m_pend = inv_req;
    end else if (inv_req) begin
      m_pend = 1;
    end
  endtask

  task automatic bool_dummy();
  endtask

  task automatic step(input int f, input int s, input int b, input bit req);
    @(negedge clk);
    if (have_exp) check(dout, exp_bit, exp_tag);
    rst_n = 1;
    frame_idx = 4'(f);
    slot_idx = 5'(s);
    bit_idx = 3'(b);
    inv_req = req;
    din = 1'($urandom);
    predict();
    have_exp = 1;
  endtask

  task automatic run_mf(input int rf, input int rs, input int rb);
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 32; s++)
        for (int b = 0; b < 8; b++)
          step(f, s, b, (f == rf && s == rs && b == rb));
  endtask

  task automatic cfg(input bit fe, input bit sg, input bit sd, input logic [2:0] sv,
                     input bit y, input bit fz, input bit fo);
    framing_en = fe; sig_gen = sg; spare_dis = sd; spare_val = sv;
    y_alarm = y; force_zero = fz; force_one = fo;
  endtask

  initial begin
    #(200000 * 10 - 100);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b1, "R1 reset");
    cfg(1, 1, 0, 3'b101, 0, 0, 0); run_mf(-1, 0, 0);
    cfg(1, 1, 0, 3'b010, 1, 0, 0); run_mf(-1, 0, 0);
    cfg(1, 1, 1, 3'b111, 1, 0, 0); run_mf(-1, 0, 0);
    cfg(1, 0, 0, 3'b101, 1, 0, 0); run_mf(-1, 0, 0);
    cfg(0, 1, 0, 3'b101, 1, 1, 1); run_mf(-1, 0, 0);
    cfg(1, 1, 0, 3'b101, 1, 0, 1); run_mf(-1, 0, 0);
    cfg(1, 1, 0, 3'b101, 1, 1, 1); run_mf(-1, 0, 0);
    cfg(1, 1, 0, 3'b011, 0, 0, 0); run_mf(0, 16, 2);
    run_mf(0, 16, 0);
    run_mf(-1, 0, 0);
    run_mf(7, 3, 1);
    cfg(1, 1, 0, 3'b011, 0, 0, 1); run_mf(-1, 0, 0);
    cfg(1, 1, 0, 3'b011, 0, 0, 0); run_mf(-1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule